// File: doc/BRIEF.md
# Wrap-Around Subroutine Return Stack

This block keeps the return addresses of a small 8-bit controller core. When the core runs a subroutine call, or an interrupt diverts it, the core asserts a push request and the block saves the current 12-bit program counter. When the core runs a return that loads a literal into the working register, the core asserts a pop request. The saved address is then shown on the output port within the same cycle, so the program counter can take it at the next clock edge.

The storage is held apart from program and data memory. Software has no access to the entry pointer. The buffer is circular. With the default depth of two, a third push writes over the oldest address. Popping more times than values were pushed gives back old contents. The block raises no overflow or underflow indication. Instruction decode, program counter arithmetic and interrupt control belong to the core.

Top module: `ret_stack`

## Requirements
- R1: An active-low reset (`rst_ni` = 0) sets the hidden pointer to entry 0 and leaves the stored addresses unchanged. The first push after reset writes entry 1, and `ret_addr_o` shows entry 0 while the block is idle after reset.
- R2: When `push_i` = 1 at a clock edge, `pc_i` is written to the next entry. A pop returns the entries in last-in, first-out order.
- R3: `ret_addr_o` always shows the entry at the pointer and has no register stage of its own. In the cycle after a push it already equals the pushed address, and in a pop cycle it shows the address being popped.
- R4: The pointer wraps modulo the depth (default 2). After three pushes A, B, C, the third push has replaced A. Three pops then return C, B, C.
- R5: A pop with `pop_i` = 1 and `push_i` = 0 moves the pointer back one entry modulo the depth and changes no entry. Extra pops cycle through the old contents and raise no error.
- R6: When `push_i` and `pop_i` are both 1 in the same cycle, the push takes place and the pop is ignored.
- R7: While both requests are 0, the pointer, the entries and `ret_addr_o` all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Power-on reset, active low |
| push_i | input | 1 | Save `pc_i` (call or interrupt branch) |
| pop_i | input | 1 | Remove the top entry (return with literal) |
| pc_i | input | 12 | Program counter value to save |
| ret_addr_o | output | 12 | Entry at the pointer, shown combinationally |

## Verification
The assertions assume that `push_i` and `pop_i` are driven to known values whenever reset is released. They also assume that the core holds each request for exactly one clock edge per instruction, so every request is counted exactly once. The bench changes the requests only on the falling clock edge and drops them again just after the rising edge. It also fills every entry before it depends on their contents, because reset leaves the stored values unspecified at power-up. Any value the bench expects to remain after a reset was written by the bench before that reset.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;

    // Push has priority over pop when both are requested
    function automatic stk_op_e decode_op(input logic push, input logic pop);
        stk_op_e op;
        if (push)     op = OP_PUSH;
        else if (pop) op = OP_POP;
        else          op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  stk_op_e          op_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] wr_idx_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t state_d, state_q;
    logic [PTR_W-1:0] inc_ptr, dec_ptr;

    localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    generate
        if (IS_POW2) begin : g_wrap_free
            assign inc_ptr = state_q.ptr + 1'b1;
            assign dec_ptr = state_q.ptr - 1'b1;
        end else begin : g_wrap_cmp
            assign inc_ptr = (state_q.ptr == PTR_W'(DEPTH - 1)) ? '0
                                                                 : state_q.ptr + 1'b1;
            assign dec_ptr = (state_q.ptr == '0) ? PTR_W'(DEPTH - 1)
                                                 : state_q.ptr - 1'b1;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        case (op_i)
            OP_PUSH: state_d.ptr = inc_ptr;
            OP_POP:  state_d.ptr = dec_ptr;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign ptr_o    = state_q.ptr;
    assign wr_idx_o = inc_ptr;

endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [PC_W-1:0]  wdata_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [PC_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] slot;
    } mem_state_t;

    mem_state_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d.slot[wr_idx_i] = wdata_i;
    end

    // Contents are deliberately left out of reset
    always_ff @(posedge clk_i) begin
        mem_q <= mem_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == PTR_W'(i)) rdata_o = mem_q.slot[i];
        end
    end

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int DEPTH = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] ret_addr_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stk_op_e          op;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] wr_idx;

    assign op = decode_op(push_i, pop_i);

    ret_stack_ptr #(
        .DEPTH (DEPTH)
    ) i_ptr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .op_i     (op),
        .ptr_o    (ptr_q),
        .wr_idx_o (wr_idx)
    );

    ret_stack_mem #(
        .PC_W  (PC_W),
        .DEPTH (DEPTH)
    ) i_mem (
        .clk_i    (clk_i),
        .we_i     (op == OP_PUSH),
        .wr_idx_i (wr_idx),
        .wdata_i  (pc_i),
        .rd_idx_i (ptr_q),
        .rdata_o  (ret_addr_o)
    );

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             push_i,
    input logic             pop_i,
    input logic [PC_W-1:0]  pc_i,
    input logic [PC_W-1:0]  ret_addr_o,
    input logic [PTR_W-1:0] ptr_q
);

    a_r1_reset_ptr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> ptr_q == '0);

    a_r2_push_lands_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i) |=> ret_addr_o == $past(pc_i));

    a_r5_pop_steps_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i) |=>
            ptr_q == (($past(ptr_q) == '0) ? PTR_W'(DEPTH - 1) : PTR_W'($past(ptr_q) - 1'b1)));

    a_r6_push_beats_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i) |=> ret_addr_o == $past(pc_i));

    a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!push_i && !pop_i) |=> ($stable(ret_addr_o) && $stable(ptr_q)));

endmodule

bind ret_stack ret_stack_chk #(
    .PC_W  (PC_W),
    .DEPTH (DEPTH)
) i_ret_stack_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .pc_i       (pc_i),
    .ret_addr_o (ret_addr_o),
    .ptr_q      (ptr_q)
);

// File: tb/test_ret_stack.sv
module test_ret_stack;

    localparam int PC_W = 12;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            push_i = 1'b0;
    logic            pop_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic [PC_W-1:0] ret_addr_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk_i = ~clk_i;

    ret_stack #(.PC_W(PC_W), .DEPTH(2)) i_ret_stack (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (push_i),
        .pop_i      (pop_i),
        .pc_i       (pc_i),
        .ret_addr_o (ret_addr_o)
    );

    task automatic check(input string req, input logic [PC_W-1:0] act,
                         input logic [PC_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic psh, input logic pp, input logic [PC_W-1:0] val);
        @(negedge clk_i);
        push_i = psh;
        pop_i  = pp;
        pc_i   = val;
        @(posedge clk_i);
        #1;
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    // Pop and check the combinational output during the pop cycle
    task automatic pop_expect(input string req, input logic [PC_W-1:0] exp);
        @(negedge clk_i);
        pop_i = 1'b1;
        #1;
        check(req, ret_addr_o, exp);
        @(posedge clk_i);
        #1;
        pop_i = 1'b0;
    endtask

    task automatic t_reset_r1();
        cycle(1'b1, 1'b0, 12'h0A1);   // entry 1
        cycle(1'b1, 1'b0, 12'h0B2);   // entry 0
        @(negedge clk_i);
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 idle after reset shows entry 0", ret_addr_o, 12'h0B2);
        cycle(1'b1, 1'b0, 12'hC33);   // must land in entry 1
        pop_expect("R1 first push after reset", 12'hC33);
        pop_expect("R1 entry 0 untouched", 12'h0B2);
    endtask

    task automatic t_lifo_r2_r3();
        cycle(1'b1, 1'b0, 12'h123);
        @(negedge clk_i);
        check("R3 top visible after push", ret_addr_o, 12'h123);
        cycle(1'b1, 1'b0, 12'h456);
        pop_expect("R2 lifo first pop", 12'h456);
        pop_expect("R2 lifo second pop", 12'h123);
    endtask

    task automatic t_overwrite_r4();
        cycle(1'b1, 1'b0, 12'h001);
        cycle(1'b1, 1'b0, 12'h002);
        cycle(1'b1, 1'b0, 12'h003);
        pop_expect("R4 third push on top", 12'h003);
        pop_expect("R4 second push kept", 12'h002);
        pop_expect("R4 first push overwritten", 12'h003);
    endtask

    task automatic t_underflow_r5();
        cycle(1'b1, 1'b0, 12'h7A7);
        cycle(1'b1, 1'b0, 12'h8B8);
        pop_expect("R5 pop 1", 12'h8B8);
        pop_expect("R5 pop 2", 12'h7A7);
        pop_expect("R5 underflow wraps", 12'h8B8);
        pop_expect("R5 underflow wraps again", 12'h7A7);
    endtask

    task automatic t_both_r6();
        cycle(1'b1, 1'b0, 12'hA0A);
        cycle(1'b1, 1'b1, 12'hB0B);
        @(negedge clk_i);
        check("R6 push wins over pop", ret_addr_o, 12'hB0B);
        pop_expect("R6 pushed value popped", 12'hB0B);
        pop_expect("R6 older value intact", 12'hA0A);
    endtask

    task automatic t_idle_r7();
        cycle(1'b1, 1'b0, 12'h5E5);
        cycle(1'b1, 1'b0, 12'hFFF);
        for (int k = 0; k < 5; k++) begin
            cycle(1'b0, 1'b0, 12'h999);
            check("R7 idle output stable", ret_addr_o, 12'hFFF);
        end
        pop_expect("R7 top after idle", 12'hFFF);
        pop_expect("R7 next after idle", 12'h5E5);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset_r1();
        t_lifo_r2_r3();
        t_overwrite_r4();
        t_underflow_r5();
        t_both_r6();
        t_idle_r7();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule